// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is the lookup controller of a read-only two-way set-associative cache, sized for an instruction cache. Each set keeps one prediction bit that names the way to probe first. A request is accepted on a ready/valid handshake. In the next cycle only the predicted way is compared. When that way holds the block, the requested word comes back at once, with the latency of a direct-mapped cache.

When the predicted way does not match, the controller stops taking requests and compares the other way one cycle later. A match there produces a slow hit, and the set's prediction bit moves to that way. When neither way matches, the controller raises a refill request with the block address and waits for the next level to return a whole line. The line is written into the least recently used way of the set, and that way becomes the predicted one. Every response carries a hit flag, a latency class (fast or slow) and the selected data word, all on one valid pulse.

Top module: `way_pred_cache`

## Requirements
- R1: After reset every entry is invalid, req_ready is 1, and rsp_valid and refill_req are 0. The first access to any address after reset therefore misses.
- R2: The lowest OFF_W address bits select a DATA_W word inside the line, with word k at line bits [k*DATA_W +: DATA_W]. The next IDX_W bits select the set and the remaining upper bits form the tag. refill_addr is the request address with the offset bits dropped.
- R3: When the predicted way holds the block, rsp_valid rises in the cycle after acceptance with rsp_hit=1, rsp_slow=0 and the addressed word. req_ready stays 1 in that cycle, so requests can be accepted back to back.
- R4: When the predicted way misses and the other way holds the block, the response comes three cycles after acceptance with rsp_hit=1, rsp_slow=1 and the addressed word.
- R5: After a slow hit, the set's prediction points at the way that hit, so the next access to that block is a fast hit.
- R6: When both ways miss, refill_req rises three cycles after acceptance. It stays high, with refill_addr unchanged, until a cycle in which refill_valid is 1.
- R7: In the cycle after refill_valid, the response comes with rsp_hit=0, rsp_slow=1 and the addressed word of refill_data. The line is stored and becomes the predicted way of its set.
- R8: Each hit or fill marks the way it used as most recently used. A fill replaces the other, least recently used way.
- R9: req_ready is 0 from the cycle of a predicted-way miss up to and including the response cycle of that access.
- R10: Sets are independent. The same tag in a different set is a separate block, and activity in one set leaves the prediction and contents of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte-free word address: tag, set index, word offset |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 = block was present, 0 = served by refill |
| rsp_slow | output | 1 | 1 = slow class (second-way hit or refill), 0 = fast hit |
| rsp_data | output | DATA_W | Addressed word |
| refill_req | output | 1 | Line needed from next level |
| refill_addr | output | ADDR_W-OFF_W | Block address of the needed line |
| refill_valid | input | 1 | refill_data holds the requested line |
| refill_data | input | DATA_W*2**OFF_W | Whole line, word 0 in the low bits |

## Verification
The bench builds the block with a 12-bit address, four sets (IDX_W=2) and four words per line (OFF_W=2). With these values a handful of tags collide in one set, so a short address list drives every prediction path. Sequences in that list fill both ways, produce slow hits in either direction, and evict the least recently used block on a third tag. The small offset field lets each response prove that the word select follows the low address bits. Refill answers are delayed by zero to two cycles, which exercises the hold of the refill request. A reset in the middle of the run shows that stored lines are discarded.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [2:0] {
    ST_LOOK,
    ST_ALT,
    ST_SLOW,
    ST_FILL_WAIT,
    ST_FILL_RSP
  } wpc_state_e;

  function automatic logic other_way(input logic way);
    return ~way;
  endfunction

endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_line = line_q[rd_idx];

  // R7
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/wpc_set_policy.sv
module wpc_set_policy #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             pred_way,
  output logic             lru_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  import wpc_pkg::*;

  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] lru_q;

  // A touched way becomes both the predicted way and the most recently used one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      lru_q  <= '0;
    end else if (touch_en) begin
      pred_q[touch_idx] <= touch_way;
      lru_q[touch_idx]  <= other_way(touch_way);
    end
  end

  assign pred_way = pred_q[rd_idx];
  assign lru_way  = lru_q[rd_idx];

endmodule

// File: rtl/way_pred_cache.sv
module way_pred_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           req_ready,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic                           rsp_slow,
  output logic [DATA_W-1:0]              rsp_data,
  output logic                           refill_req,
  output logic [ADDR_W-OFF_W-1:0]        refill_addr,
  input  logic                           refill_valid,
  input  logic [DATA_W*(2**OFF_W)-1:0]   refill_data
);
  import wpc_pkg::*;

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [OFF_W-1:0]  off);
    return line[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  wpc_state_e          st_q;
  logic                vld_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LINE_W-1:0]   line_q;

  logic [IDX_W-1:0]    idx_q;
  logic [TAG_W-1:0]    tag_q;
  logic [OFF_W-1:0]    off_q;

  logic                way_vld  [2];
  logic [TAG_W-1:0]    way_tag  [2];
  logic [LINE_W-1:0]   way_line [2];
  logic [1:0]          way_match;
  logic [1:0]          way_wr;

  logic                pred_w;
  logic                lru_w;
  logic                alt_w;

  // Named internal events
  logic                pred_hit;
  logic                pred_miss;
  logic                alt_hit;
  logic                alt_miss;
  logic                fill_evt;
  logic                accept;
  logic                touch_en;
  logic                touch_way;

  assign idx_q = index_of(addr_q);
  assign tag_q = tag_of(addr_q);
  assign off_q = addr_q[OFF_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    wpc_way_store #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx_q),
      .rd_vld  (way_vld[w]),
      .rd_tag  (way_tag[w]),
      .rd_line (way_line[w]),
      .wr_en   (way_wr[w]),
      .wr_idx  (idx_q),
      .wr_tag  (tag_q),
      .wr_line (refill_data)
    );
    assign way_match[w] = way_vld[w] && (way_tag[w] == tag_q);
    assign way_wr[w]    = fill_evt && (lru_w == w[0]);
  end

  wpc_set_policy #(
    .IDX_W (IDX_W)
  ) u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx_q),
    .pred_way  (pred_w),
    .lru_way   (lru_w),
    .touch_en  (touch_en),
    .touch_idx (idx_q),
    .touch_way (touch_way)
  );

  assign alt_w     = other_way(pred_w);
  assign pred_hit  = vld_q && (st_q == ST_LOOK) && way_match[pred_w];
  assign pred_miss = vld_q && (st_q == ST_LOOK) && !way_match[pred_w];
  assign alt_hit   = (st_q == ST_ALT) && way_match[alt_w];
  assign alt_miss  = (st_q == ST_ALT) && !way_match[alt_w];
  assign fill_evt  = (st_q == ST_FILL_WAIT) && refill_valid;

  assign touch_en  = pred_hit || alt_hit || fill_evt;
  assign touch_way = pred_hit ? pred_w : (alt_hit ? alt_w : lru_w);

  assign req_ready = (st_q == ST_LOOK) && (!vld_q || pred_hit);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_LOOK;
      vld_q  <= 1'b0;
      addr_q <= '0;
      line_q <= '0;
    end else begin
      unique case (st_q)
        ST_LOOK: begin
          if (accept) begin
            addr_q <= req_addr;
            vld_q  <= 1'b1;
          end else if (pred_hit) begin
            vld_q  <= 1'b0;
          end
          if (pred_miss) st_q <= ST_ALT;
        end
        ST_ALT: begin
          if (alt_hit) begin
            line_q <= way_line[alt_w];
            st_q   <= ST_SLOW;
          end else begin
            st_q   <= ST_FILL_WAIT;
          end
        end
        ST_FILL_WAIT: begin
          if (refill_valid) begin
            line_q <= refill_data;
            st_q   <= ST_FILL_RSP;
          end
        end
        ST_SLOW, ST_FILL_RSP: begin
          vld_q <= 1'b0;
          st_q  <= ST_LOOK;
        end
        default: st_q <= ST_LOOK;
      endcase
    end
  end

  assign rsp_valid   = pred_hit || (st_q == ST_SLOW) || (st_q == ST_FILL_RSP);
  assign rsp_hit     = pred_hit || (st_q == ST_SLOW);
  assign rsp_slow    = (st_q != ST_LOOK);
  assign rsp_data    = pred_hit ? word_of(way_line[pred_w], off_q) : word_of(line_q, off_q);
  assign refill_req  = (st_q == ST_FILL_WAIT);
  assign refill_addr = addr_q[ADDR_W-1:OFF_W];

  // R3
  fast_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_slow) |-> (req_ready && rsp_hit));

  // R4
  slow_after_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_hit |=> (rsp_valid && rsp_hit && rsp_slow));

  // R5
  pred_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_hit |=> (pred_w == $past(alt_w)));

  // R6
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

  // R6
  miss_to_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_miss |=> refill_req);

  // R7
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && refill_valid) |=> (rsp_valid && !rsp_hit && rsp_slow));

  // R8
  lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (lru_w != $past(lru_w)) && (pred_w == $past(lru_w)));

  // R9
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_miss || alt_hit || alt_miss || refill_req) |-> !req_ready);

endmodule

// File: tb/way_pred_cache_tb.sv
module way_pred_cache_tb;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 2;
  localparam int OFF_W  = 2;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int NVEC   = 16;

  // {class, address}: class 0 = fast hit, 1 = slow hit, 2 = miss
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd2, 12'h104}, {2'd0, 12'h105}, {2'd2, 12'h204}, {2'd1, 12'h106},
    {2'd0, 12'h107}, {2'd1, 12'h204}, {2'd2, 12'h304}, {2'd2, 12'h104},
    {2'd1, 12'h304}, {2'd2, 12'h108}, {2'd0, 12'h10B}, {2'd0, 12'h304},
    {2'd2, 12'hFFC}, {2'd0, 12'hFFF}, {2'd2, 12'h000}, {2'd0, 12'h001}
  };

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      req_valid = 1'b0;
  logic [ADDR_W-1:0]         req_addr = '0;
  logic                      req_ready;
  logic                      rsp_valid;
  logic                      rsp_hit;
  logic                      rsp_slow;
  logic [DATA_W-1:0]         rsp_data;
  logic                      refill_req;
  logic [BLK_W-1:0]          refill_addr;
  logic                      refill_valid = 1'b0;
  logic [DATA_W*WORDS-1:0]   refill_data = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  way_pred_cache #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_slow     (rsp_slow),
    .rsp_data     (rsp_data),
    .refill_req   (refill_req),
    .refill_addr  (refill_addr),
    .refill_valid (refill_valid),
    .refill_data  (refill_data)
  );

  function automatic logic [DATA_W-1:0] word_val(input logic [BLK_W-1:0] blk, input int k);
    return 32'hA500_0000 | (32'(blk) << 4) | 32'(k);
  endfunction

  function automatic logic [DATA_W*WORDS-1:0] line_val(input logic [BLK_W-1:0] blk);
    logic [DATA_W*WORDS-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*DATA_W +: DATA_W] = word_val(blk, k);
    return l;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int cls, input int delay);
    int cyc;
    int waited;
    bit seen_refill;
    bit got;
    logic [BLK_W-1:0] blk;
    blk = a[ADDR_W-1:OFF_W];
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid   = 1'b0;
    cyc         = 1;
    waited      = 0;
    seen_refill = 1'b0;
    got         = 1'b0;
    while (cyc < 40) begin
      refill_valid = 1'b0;
      if (rsp_valid) begin
        got = 1'b1;
        break;
      end
      if (req_ready !== 1'b0) chk(1'b0, "R9 ready high while access pending", req_ready, 0);
      if (refill_req) begin
        if (!seen_refill) begin
          seen_refill = 1'b1;
          chk(cyc == 3, "R6 refill request cycle", cyc, 3);
        end
        if (refill_addr !== blk) chk(1'b0, "R2/R6 refill address", refill_addr, blk);
        if (waited == delay) begin
          refill_valid = 1'b1;
          refill_data  = line_val(blk);
        end else begin
          waited++;
        end
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk(got, "response seen", got, 1);
    case (cls)
      0: begin
        chk(cyc == 1, "R3 fast latency", cyc, 1);
        chk(rsp_hit && !rsp_slow, "R3 fast flags", {rsp_hit, rsp_slow}, 2'b10);
        chk(req_ready == 1'b1, "R3 ready in fast response", req_ready, 1);
      end
      1: begin
        chk(cyc == 3, "R4 slow latency", cyc, 3);
        chk(rsp_hit && rsp_slow, "R4 slow flags", {rsp_hit, rsp_slow}, 2'b11);
        chk(req_ready == 1'b0, "R9 ready in slow response", req_ready, 0);
      end
      default: begin
        chk(cyc == 4 + delay, "R7 miss latency", cyc, 4 + delay);
        chk(!rsp_hit && rsp_slow, "R7 miss flags", {rsp_hit, rsp_slow}, 2'b01);
        chk(req_ready == 1'b0, "R9 ready in fill response", req_ready, 0);
      end
    endcase
    chk(seen_refill == (cls == 2), "R6 refill only on double miss", seen_refill, cls == 2);
    chk(rsp_data == word_val(blk, int'(a[OFF_W-1:0])), "R2 response word", rsp_data,
        word_val(blk, int'(a[OFF_W-1:0])));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(refill_req == 1'b0, "R1 no refill after reset", refill_req, 0);
    rst_n = 1'b1;

    // Table walk: R4 R5 (slow hits then fast), R8 (vectors 6,7 evict LRU), R10 (set 2/3/0 blocks)
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][11:0], int'(VEC[i][13:12]), i % 3);
    end

    // R3 back-to-back fast hits
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 12'h109;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && !rsp_slow, "R3 first back-to-back response", {rsp_valid, rsp_slow}, 2'b10);
    chk(rsp_data == word_val(10'h042, 1), "R3 first back-to-back data", rsp_data, word_val(10'h042, 1));
    chk(req_ready == 1'b1, "R3 ready for second request", req_ready, 1);
    req_addr = 12'h002;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_slow, "R3 second back-to-back response", {rsp_valid, rsp_slow}, 2'b10);
    chk(rsp_data == word_val(10'h000, 2), "R3 second back-to-back data", rsp_data, word_val(10'h000, 2));

    // R1 reset in mid-run discards stored lines
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 state after second reset",
        {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    access(12'h304, 2, 1);
    access(12'h305, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule